// File: doc/BRIEF.md
# DAC Channel Conversion Trigger Controller

This block decides, for each of two converter channels, the clock cycle in which a conversion begins. A prescaler divides the peripheral clock into a converter tick. Every conversion start is lined up with one of these ticks. Each channel picks its trigger source through a three-bit mode. The sources are data writes, a rising edge on one of twelve selectable event lines, a refresh timer that counts ticks, or a pulse from a sensor sequencer. A trigger that arrives between ticks is held pending until the next tick. On that tick the channel raises a one-cycle start pulse and latches the value to convert.

Data enters through two bus words, one per channel, qualified by a per-channel write strobe or by a combined strobe that loads both channels at once. A word whose value does not fit in twelve bits is refused. Options let a channel-0 trigger restart the prescaler, so that its start lands a fixed number of cycles later. A further option lets the level on channel 1's selected event line gate the output enable. A per-channel sample/shut-off setting limits the output drive to one tick period after each start.

Top module: `dac_trig_ctrl`

## Requirements
- R1: `dac_tick` is high in one cycle out of every `presc_div`+1 cycles; with `presc_div` = 0 it is high in every cycle.
- R2: A channel's `conv_start` bit is a one-cycle pulse in the cycle after a tick cycle in which the channel had a pending or new trigger. A trigger that arrives in a non-tick cycle waits for the next tick. `conv_dataN` holds the value latched with the last start.
- R3: Mode codes per channel (`ch_mode[3c+2:3c]`): 0 write, 1 event, 2 refresh, 3 write or event, 4 write or refresh, 5 sensor pulse; codes 6 and 7 never trigger. A channel responds only to the sources its mode names.
- R4: `wr_ch[c]` loads and triggers channel c only. `wr_comb` loads `wdat0` into channel 0 and `wdat1` into channel 1 and triggers both.
- R5: A write whose bus word exceeds 4095 is ignored: it neither triggers nor changes the held value. 4095 is accepted.
- R6: The refresh timer fires every 8, 16, 32 or 64 ticks for `refresh_sel` = 0, 1, 2, 3.
- R7: `ch_ev_sel` (4 bits per channel) picks event line 0 to 11. Values 12 and above select no line. Only a rising edge triggers; a held-high line does not trigger again.
- R8: With `ch_ev_async[c]` = 1 the edge is taken from the raw line. With 0 it passes a two-stage synchroniser and the start comes two cycles later.
- R9: With `ch0_presc_sync_en` = 1, a new channel-0 trigger in a non-tick cycle clears the prescaler, so the start follows `presc_div`+1 cycles later.
- R10: With `oe_from_ev1_en` = 0, `out_en` is 1. With 1, `out_en` follows the level of channel 1's selected event line, raw or synchronised per `ch_ev_async[1]`.
- R11: In continuous mode, `ch_drive[c]` equals `ch_en[c]`. In sample/shut-off mode (`ch_sample_off[c]` = 1), it rises with the start pulse and falls after the next tick.
- R12: Out of reset all outputs except `out_en` are 0. Clearing `ch_en[c]` drops a pending trigger and holds the channel's refresh count at zero.
- R13: A write and another trigger in the same cycle give one start pulse that carries the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_div | input | PW | Prescaler divide value minus one |
| refresh_sel | input | 2 | Refresh period code |
| ch0_presc_sync_en | input | 1 | Channel-0 trigger restarts the prescaler |
| oe_from_ev1_en | input | 1 | Output enable follows channel 1's event line |
| ch_en | input | 2 | Channel enables |
| ch_mode | input | 6 | Trigger mode, three bits per channel |
| ch_ev_sel | input | 2*SW | Event line select per channel |
| ch_ev_async | input | 2 | Take event edge unsynchronised |
| ch_sample_off | input | 2 | Sample/shut-off drive mode |
| wr_ch | input | 2 | Per-channel data write strobes |
| wr_comb | input | 1 | Combined write strobe for both channels |
| wdat0 | input | BUS_W | Write word for channel 0 |
| wdat1 | input | BUS_W | Write word for channel 1 |
| ev_in | input | NUM_EV | External event lines |
| sns_trig | input | 2 | Sensor sequencer trigger pulses |
| dac_tick | output | 1 | Prescaled converter clock enable |
| conv_start | output | 2 | Conversion start pulses |
| conv_data0 | output | DW | Value latched for channel 0 |
| conv_data1 | output | DW | Value latched for channel 1 |
| ch_drive | output | 2 | Per-channel output drive |
| out_en | output | 1 | Shared output enable |

## Verification
A prescaler count that has drifted moves every start by the same offset. That error shows on `conv_start` within one tick period, and on `dac_tick` spacing at once. A pending flag that is not cleared gives a second start pulse on the very next tick. A refresh count that is not held while disabled makes the first refresh start after re-enable come early, so the gap from enable to start shows it. A wrong synchroniser depth moves the event-to-start latency away from exactly three cycles.

// File: rtl/dac_trig_pkg.sv
package dac_trig_pkg;

  localparam int NCH   = 2;
  localparam int REF_W = 7;

  typedef enum logic [2:0] {
    TM_WRITE   = 3'd0,
    TM_EVENT   = 3'd1,
    TM_REFRESH = 3'd2,
    TM_WR_EV   = 3'd3,
    TM_WR_REF  = 3'd4,
    TM_SENSOR  = 3'd5
  } trig_mode_e;

  function automatic logic mode_has_write(input logic [2:0] m);
    return (m == TM_WRITE) || (m == TM_WR_EV) || (m == TM_WR_REF);
  endfunction

  function automatic logic mode_has_event(input logic [2:0] m);
    return (m == TM_EVENT) || (m == TM_WR_EV);
  endfunction

  function automatic logic mode_has_refresh(input logic [2:0] m);
    return (m == TM_REFRESH) || (m == TM_WR_REF);
  endfunction

  function automatic logic mode_has_sensor(input logic [2:0] m);
    return m == TM_SENSOR;
  endfunction

  // Refresh length in ticks: 8 shifted left by the select code.
  function automatic logic [REF_W-1:0] refresh_len(input logic [1:0] sel);
    return REF_W'(8) << sel;
  endfunction

  // True when the bus word has no bit set at or above position dw.
  function automatic logic value_fits(input logic [31:0] v, input int unsigned dw);
    return (v >> dw) == 32'd0;
  endfunction

endpackage

// File: rtl/dac_presc.sv
module dac_presc #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] div,
  input  logic          restart,
  output logic          tick
);

  logic [PW-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (tick || restart) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R1: no division means a tick in every cycle
  assert_undivided_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0 && $past(div) == '0) |-> tick);

  // R1: two ticks are never back to back when dividing
  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (div != '0 && $past(div) == div && !$past(restart) && $past(tick)) |-> !tick);

endmodule

// File: rtl/dac_ev_sync.sv
module dac_ev_sync #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_in,
  output logic [N-1:0] async_rise,
  output logic [N-1:0] sync_rise,
  output logic [N-1:0] sync_lvl
);

  logic [N-1:0] raw_q, s1, s2, s3;
  logic [1:0]   age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      s1    <= '0;
      s2    <= '0;
      s3    <= '0;
      age   <= '0;
    end else begin
      raw_q <= ev_in;
      s1    <= ev_in;
      s2    <= s1;
      s3    <= s2;
      if (age != 2'd3) age <= age + 1'b1;
    end
  end

  assign async_rise = ev_in & ~raw_q;
  assign sync_rise  = s2 & ~s3;
  assign sync_lvl   = s2;

  // R8: the synchronised edge is the raw edge two cycles late
  assert_sync_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (sync_rise == $past(async_rise, 2)));

endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_trig_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [2:0]    mode,
  input  logic          sample_off,
  input  logic [1:0]    ref_sel,
  input  logic          tick,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_val,
  input  logic          ev_rise,
  input  logic          sns,
  output logic          start,
  output logic [DW-1:0] data,
  output logic          drive,
  output logic          trig_new
);

  logic [REF_W-1:0] ref_cnt;
  logic [REF_W-1:0] ref_last;
  logic             ref_hit;
  logic             pend;
  logic             start_now;
  logic             drv_q;
  logic [DW-1:0]    hold;
  logic [DW-1:0]    data_next;

  assign ref_last  = refresh_len(ref_sel) - 1'b1;
  assign ref_hit   = en & tick & (ref_cnt >= ref_last);

  assign trig_new  = en & ((mode_has_write(mode)   & wr_hit)  |
                           (mode_has_event(mode)   & ev_rise) |
                           (mode_has_refresh(mode) & ref_hit) |
                           (mode_has_sensor(mode)  & sns));

  assign start_now = en & tick & (pend | trig_new);
  assign data_next = wr_hit ? wr_val : hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold    <= '0;
      ref_cnt <= '0;
      pend    <= 1'b0;
      start   <= 1'b0;
      data    <= '0;
      drv_q   <= 1'b0;
    end else begin
      if (wr_hit) hold <= wr_val;

      if (!en)       ref_cnt <= '0;
      else if (tick) ref_cnt <= ref_hit ? '0 : ref_cnt + 1'b1;

      if (!en || start_now) pend <= 1'b0;
      else                  pend <= pend | trig_new;

      start <= start_now;
      if (start_now) data <= data_next;

      if (!en)            drv_q <= 1'b0;
      else if (start_now) drv_q <= 1'b1;
      else if (tick)      drv_q <= 1'b0;
    end
  end

  assign drive = en & (sample_off ? drv_q : 1'b1);

  // R2: every start follows a tick cycle
  assert_start_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(tick));

  // R2: a start leaves nothing pending behind it
  assert_start_clears_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !pend);

  // R12: a channel that was disabled issues no start
  assert_disabled_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !start);

  // R11: a start in sample/shut-off mode is driven
  assert_drive_on_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && en && sample_off) |-> drive);

endmodule

// File: rtl/dac_trig_ctrl.sv
module dac_trig_ctrl
  import dac_trig_pkg::*;
#(
  parameter int PW     = 8,
  parameter int DW     = 12,
  parameter int BUS_W  = 16,
  parameter int NUM_EV = 12,
  parameter int SW     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PW-1:0]       presc_div,
  input  logic [1:0]          refresh_sel,
  input  logic                ch0_presc_sync_en,
  input  logic                oe_from_ev1_en,
  input  logic [NCH-1:0]      ch_en,
  input  logic [3*NCH-1:0]    ch_mode,
  input  logic [SW*NCH-1:0]   ch_ev_sel,
  input  logic [NCH-1:0]      ch_ev_async,
  input  logic [NCH-1:0]      ch_sample_off,
  input  logic [NCH-1:0]      wr_ch,
  input  logic                wr_comb,
  input  logic [BUS_W-1:0]    wdat0,
  input  logic [BUS_W-1:0]    wdat1,
  input  logic [NUM_EV-1:0]   ev_in,
  input  logic [NCH-1:0]      sns_trig,
  output logic                dac_tick,
  output logic [NCH-1:0]      conv_start,
  output logic [DW-1:0]       conv_data0,
  output logic [DW-1:0]       conv_data1,
  output logic [NCH-1:0]      ch_drive,
  output logic                out_en
);

  logic [NUM_EV-1:0] ev_async_rise, ev_sync_rise, ev_sync_lvl;
  logic [NCH-1:0]    trig_new;
  logic [NCH-1:0]    wr_hit;
  logic [NCH-1:0]    ev_pick;
  logic [DW-1:0]     wr_val  [NCH];
  logic [DW-1:0]     ch_data [NCH];
  logic [BUS_W-1:0]  bus_word [NCH];
  logic              presc_restart;
  logic              ev1_level;
  logic [SW-1:0]     sel1;

  assign bus_word[0] = wdat0;
  assign bus_word[1] = wdat1;

  dac_presc #(.PW(PW)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .div     (presc_div),
    .restart (presc_restart),
    .tick    (dac_tick)
  );

  dac_ev_sync #(.N(NUM_EV)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_in      (ev_in),
    .async_rise (ev_async_rise),
    .sync_rise  (ev_sync_rise),
    .sync_lvl   (ev_sync_lvl)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SW-1:0] sel;
    assign sel = ch_ev_sel[c*SW +: SW];

    always_comb begin
      ev_pick[c] = 1'b0;
      for (int k = 0; k < NUM_EV; k++) begin
        if (sel == SW'(k))
          ev_pick[c] = ch_ev_async[c] ? ev_async_rise[k] : ev_sync_rise[k];
      end
    end

    assign wr_hit[c] = (wr_ch[c] | wr_comb) &
                       value_fits(32'(bus_word[c]), DW);
    assign wr_val[c] = bus_word[c][DW-1:0];

    dac_chan #(.DW(DW)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (ch_en[c]),
      .mode       (ch_mode[3*c +: 3]),
      .sample_off (ch_sample_off[c]),
      .ref_sel    (refresh_sel),
      .tick       (dac_tick),
      .wr_hit     (wr_hit[c]),
      .wr_val     (wr_val[c]),
      .ev_rise    (ev_pick[c]),
      .sns        (sns_trig[c]),
      .start      (conv_start[c]),
      .data       (ch_data[c]),
      .drive      (ch_drive[c]),
      .trig_new   (trig_new[c])
    );
  end

  assign conv_data0    = ch_data[0];
  assign conv_data1    = ch_data[1];
  assign presc_restart = ch0_presc_sync_en & trig_new[0];

  assign sel1 = ch_ev_sel[SW +: SW];
  always_comb begin
    ev1_level = 1'b0;
    for (int k = 0; k < NUM_EV; k++) begin
      if (sel1 == SW'(k))
        ev1_level = ch_ev_async[1] ? ev_in[k] : ev_sync_lvl[k];
    end
  end

  assign out_en = oe_from_ev1_en ? ev1_level : 1'b1;

  // R10: with the gating option off the output stays enabled
  assert_oe_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_from_ev1_en |-> out_en);

  // R4: a combined write with fitting words starts both enabled write-mode channels
  assert_comb_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_comb && dac_tick && ch_en == 2'b11 && ch_mode == 6'd0 &&
     value_fits(32'(wdat0), DW) && value_fits(32'(wdat1), DW))
    |=> conv_start == 2'b11);

endmodule

// File: tb/dac_trig_ctrl_test.sv
`timescale 1ns/1ps
module dac_trig_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  presc_div = '0;
  logic [1:0]  refresh_sel = '0;
  logic        ch0_presc_sync_en = 1'b0;
  logic        oe_from_ev1_en = 1'b0;
  logic [1:0]  ch_en = '0;
  logic [5:0]  ch_mode = '0;
  logic [7:0]  ch_ev_sel = '0;
  logic [1:0]  ch_ev_async = 2'b11;
  logic [1:0]  ch_sample_off = '0;
  logic [1:0]  wr_ch = '0;
  logic        wr_comb = 1'b0;
  logic [15:0] wdat0 = '0;
  logic [15:0] wdat1 = '0;
  logic [11:0] ev_in = '0;
  logic [1:0]  sns_trig = '0;
  logic        dac_tick;
  logic [1:0]  conv_start;
  logic [11:0] conv_data0, conv_data1;
  logic [1:0]  ch_drive;
  logic        out_en;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dac_trig_ctrl uut (
    .clk(clk), .rst_n(rst_n), .presc_div(presc_div), .refresh_sel(refresh_sel),
    .ch0_presc_sync_en(ch0_presc_sync_en), .oe_from_ev1_en(oe_from_ev1_en),
    .ch_en(ch_en), .ch_mode(ch_mode), .ch_ev_sel(ch_ev_sel),
    .ch_ev_async(ch_ev_async), .ch_sample_off(ch_sample_off), .wr_ch(wr_ch),
    .wr_comb(wr_comb), .wdat0(wdat0), .wdat1(wdat1), .ev_in(ev_in),
    .sns_trig(sns_trig), .dac_tick(dac_tick), .conv_start(conv_start),
    .conv_data0(conv_data0), .conv_data1(conv_data1), .ch_drive(ch_drive),
    .out_en(out_en)
  );

  // {mode, stimulus (0 write, 1 event, 2 sensor), expected start} for R3
  localparam logic [5:0] VEC [21] = '{
    {3'd0,2'd0,1'b1}, {3'd0,2'd1,1'b0}, {3'd0,2'd2,1'b0},
    {3'd1,2'd0,1'b0}, {3'd1,2'd1,1'b1}, {3'd1,2'd2,1'b0},
    {3'd2,2'd0,1'b0}, {3'd2,2'd1,1'b0}, {3'd2,2'd2,1'b0},
    {3'd3,2'd0,1'b1}, {3'd3,2'd1,1'b1}, {3'd3,2'd2,1'b0},
    {3'd4,2'd0,1'b1}, {3'd4,2'd1,1'b0}, {3'd4,2'd2,1'b0},
    {3'd5,2'd0,1'b0}, {3'd5,2'd1,1'b0}, {3'd5,2'd2,1'b1},
    {3'd6,2'd0,1'b0}, {3'd6,2'd1,1'b0}, {3'd6,2'd2,1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic nx();
    @(negedge clk);
  endtask

  task automatic find_tick();
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (dac_tick) break;
    end
  endtask

  // samples until channel 0 starts, the start sample included
  task automatic gap0(output int n);
    n = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      n++;
      if (conv_start[0]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int g;
    repeat (3) nx();
    // R12 reset state
    chk("R12 start", conv_start, 0);
    chk("R12 data0", conv_data0, 0);
    chk("R12 drive", ch_drive, 0);
    chk("R10 oe default", out_en, 1);
    rst_n = 1'b1;
    nx();

    // R3 table walk, presc 0
    for (int i = 0; i < 21; i++) begin
      ch_mode[2:0] = VEC[i][5:3];
      ch_en[0] = 1'b1;
      wdat0 = 16'(100 + i);
      case (VEC[i][2:1])
        2'd0: wr_ch[0] = 1'b1;
        2'd1: ev_in[0] = 1'b1;
        default: sns_trig[0] = 1'b1;
      endcase
      nx();
      chk($sformatf("R3 vec %0d", i), conv_start[0], VEC[i][0]);
      if (VEC[i][0] && VEC[i][2:1] == 2'd0) chk("R2 data", conv_data0, 100 + i);
      wr_ch = '0; ev_in = '0; sns_trig = '0; ch_en = '0;
      nx(); nx();
    end

    // R4 combined and single writes
    ch_mode = 6'd0; ch_en = 2'b11;
    wdat0 = 16'h111; wdat1 = 16'h222; wr_comb = 1'b1;
    nx();
    chk("R4 comb start", conv_start, 3);
    chk("R4 comb d0", conv_data0, 'h111);
    chk("R4 comb d1", conv_data1, 'h222);
    wr_comb = 1'b0; wdat1 = 16'h333; wr_ch = 2'b10;
    nx();
    chk("R4 single start", conv_start, 2);
    chk("R4 single d1", conv_data1, 'h333);
    chk("R4 d0 kept", conv_data0, 'h111);
    wr_ch = '0;
    nx();

    // R5 value range
    wdat0 = 16'h1000; wr_ch = 2'b01;
    nx();
    chk("R5 refused start", conv_start[0], 0);
    wr_ch = '0;
    nx();
    chk("R5 refused start later", conv_start[0], 0);
    wdat0 = 16'h0FFF; wr_ch = 2'b01;
    nx();
    chk("R5 max start", conv_start[0], 1);
    chk("R5 max data", conv_data0, 'hFFF);
    wr_ch = '0; ch_en = '0;
    nx();

    // R13 write with event in one cycle
    ch_mode[2:0] = 3'd3; ch_en[0] = 1'b1; ch_ev_sel[3:0] = 4'd0;
    wdat0 = 16'h5A5; wr_ch = 2'b01; ev_in[0] = 1'b1;
    nx();
    chk("R13 start", conv_start[0], 1);
    chk("R13 data", conv_data0, 'h5A5);
    wr_ch = '0; ev_in = '0;
    nx();
    chk("R13 single pulse", conv_start[0], 0);

    // R7 selection range and edge only
    ch_mode[2:0] = 3'd1; ch_ev_sel[3:0] = 4'd11;
    ev_in[11] = 1'b1;
    nx();
    chk("R7 line 11", conv_start[0], 1);
    nx(); nx();
    chk("R7 level no retrigger", conv_start[0], 0);
    ev_in = '0; ch_ev_sel[3:0] = 4'd12;
    nx();
    ev_in = '1;
    nx();
    chk("R7 select 12 none", conv_start[0], 0);
    nx(); nx(); nx();
    chk("R7 select 12 none late", conv_start[0], 0);
    ev_in = '0;

    // R8 synchronised event two cycles later
    ch_ev_sel[3:0] = 4'd0; ch_ev_async[0] = 1'b0;
    nx(); nx(); nx();
    ev_in[0] = 1'b1;
    nx();
    chk("R8 sync +1", conv_start[0], 0);
    ev_in = '0;
    nx();
    chk("R8 sync +2", conv_start[0], 0);
    nx();
    chk("R8 sync +3", conv_start[0], 1);
    ch_ev_async[0] = 1'b1;

    // R10 output enable from channel 1 event line
    oe_from_ev1_en = 1'b1; ch_ev_sel[7:4] = 4'd2; ch_ev_async[1] = 1'b1;
    ev_in[2] = 1'b0; #1;
    chk("R10 oe low", out_en, 0);
    ev_in[2] = 1'b1; #1;
    chk("R10 oe high", out_en, 1);
    ev_in = '0; oe_from_ev1_en = 1'b0;
    nx();

    // R1 tick spacing
    ch_mode[2:0] = 3'd0; presc_div = 8'd3;
    find_tick();
    for (int j = 1; j <= 8; j++) begin
      nx();
      chk($sformatf("R1 tick %0d", j), dac_tick, (j % 4 == 0) ? 1 : 0);
    end

    // R2 trigger waits for the tick
    find_tick();
    nx();
    wdat0 = 16'h0AB; wr_ch = 2'b01;
    nx();
    chk("R2 wait +1", conv_start[0], 0);
    wr_ch = '0;
    nx(); nx();
    chk("R2 wait +3", conv_start[0], 0);
    nx();
    chk("R2 start at tick", conv_start[0], 1);
    chk("R2 data at tick", conv_data0, 'h0AB);
    nx();
    chk("R2 one cycle", conv_start[0], 0);

    // R9 prescaler restart
    find_tick(); nx(); nx();
    wr_ch = 2'b01;
    nx(); wr_ch = '0; nx(); nx();
    chk("R9 no restart +3", conv_start[0], 1);
    ch0_presc_sync_en = 1'b1;
    find_tick(); nx(); nx();
    wr_ch = 2'b01;
    nx(); wr_ch = '0; nx(); nx();
    chk("R9 restart +3", conv_start[0], 0);
    nx(); nx();
    chk("R9 restart +5", conv_start[0], 1);
    ch0_presc_sync_en = 1'b0;

    // R11 sample/shut-off drive
    ch_sample_off[0] = 1'b1;
    find_tick(); nx();
    chk("R11 idle drive", ch_drive[0], 0);
    wr_ch = 2'b01;
    nx(); wr_ch = '0; nx(); nx(); nx();
    chk("R11 start", conv_start[0], 1);
    chk("R11 drive at start", ch_drive[0], 1);
    nx(); nx(); nx();
    chk("R11 drive held", ch_drive[0], 1);
    nx();
    chk("R11 drive off", ch_drive[0], 0);
    ch_sample_off[0] = 1'b0; #1;
    chk("R11 continuous", ch_drive[0], 1);

    // R12 disable drops the pending trigger
    find_tick(); nx();
    wr_ch = 2'b01;
    nx(); wr_ch = '0; ch_en[0] = 1'b0;
    nx(); ch_en[0] = 1'b1;
    g = 0;
    for (int j = 0; j < 8; j++) begin
      nx();
      if (conv_start[0]) g++;
    end
    chk("R12 pending dropped", g, 0);

    // R6 refresh periods, and R12 counter held while disabled
    presc_div = 8'd0; ch_mode[2:0] = 3'd2; refresh_sel = 2'd0; ch_en = '0;
    nx();
    ch_en[0] = 1'b1;
    nx(); nx(); nx(); nx();
    ch_en[0] = 1'b0;
    nx();
    ch_en[0] = 1'b1;
    gap0(g);
    chk("R12 refresh restart", g, 8);
    ch_en = '0; refresh_sel = 2'd1;
    nx();
    ch_en[0] = 1'b1;
    gap0(g);
    chk("R6 period 16 first", g, 16);
    gap0(g);
    chk("R6 period 16", g, 16);
    refresh_sel = 2'd3; ch_en = '0;
    nx();
    ch_en[0] = 1'b1;
    gap0(g);
    chk("R6 period 64", g, 64);
    refresh_sel = 2'd0; presc_div = 8'd1;
    gap0(g);
    gap0(g);
    chk("R6 period 8 ticks at div 2", g, 16);
    ch_en = '0;
    nx();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule